// File: doc/BRIEF.md
# Iterative Match Walker

This block sits at the end of a bit-serial associative search. When the search completes, the per-row hit vector is captured into a private match buffer. The block then presents one matching row at a time. It gives a one-hot row select for the lowest-numbered row still pending, the binary row number of that row, a valid flag, and the number of hits counted when the vector was captured.

A consumer steps through the hits with an advance command. Each advance retires the row currently presented and moves the selection to the next higher pending row. The one-hot output is registered and is suitable to drive a row wordline directly in the cycle after it appears. A read-after-search or write-after-search therefore needs no address decoder. Taken together, the one-hot output and the binary row number act as a priority encoder that is used up destructively.

Top module: `match_walker`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, valid is 0, the one-hot select is all zero, the index is 0 and the count is 0.
- R2: A load captures the match vector (bit r set means row r matched). On the cycle after the load edge, the one-hot select has exactly one bit set, at the lowest-numbered set row.
- R3: While valid is 1, the index equals the bit position of the single 1 in the one-hot select.
- R4: On the cycle after a load edge, the count equals the number of set bits in the loaded vector.
- R5: An advance without a load clears the buffer bit of the row currently presented. On the cycle after the advance, the one-hot select moves to the next higher pending row, and a retired row is never selected again.
- R6: The count is not changed by an advance.
- R7: When no pending bit remains, valid is 0, the one-hot select is zero and the index is 0. An advance in that state changes no output.
- R8: When load and advance are high in the same cycle, the load is taken and the advance is dropped. The newly loaded lowest row is presented and no bit of the new vector is cleared.
- R9: In a cycle with neither load nor advance, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture match_i into the buffer |
| next_i | input | 1 | Retire the presented row and advance |
| match_i | input | ROWS | Per-row search hit vector |
| sel_onehot_o | output | ROWS | One-hot select of the presented row |
| sel_index_o | output | IDX_W | Binary number of the presented row |
| sel_valid_o | output | 1 | A pending row is presented |
| match_count_o | output | CNT_W | Hit count captured at load |

## Verification
Capture and advance can both be requested in the same cycle. The bench provokes this by loading a vector while the previous one is still being walked, with the advance held high at the same edge. It judges the result by checking three things: the lowest bit of the new vector is presented, the new count appears, and no bit of the new vector goes missing over the following advances. A second case issues an advance on an empty buffer. Here the bench confirms that every output holds its value.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    MW_HOLD = 2'd0,
    MW_LOAD = 2'd1,
    MW_STEP = 2'd2
  } mw_cmd_e;
endpackage

// File: rtl/mw_first_pick.sv
module mw_first_pick #(
  parameter int ROWS = 32
) (
  input  logic [ROWS-1:0] pend_i,
  output logic [ROWS-1:0] pick_o
);
  // lower_any[r] is high when any row below r is pending
  logic [ROWS:0] lower_any;
  assign lower_any[0] = 1'b0;

  for (genvar r = 0; r < ROWS; r++) begin : g_chain
    assign lower_any[r+1] = lower_any[r] | pend_i[r];
    assign pick_o[r]      = pend_i[r] & ~lower_any[r];
  end
endmodule

// File: rtl/mw_index_enc.sv
module mw_index_enc #(
  parameter int ROWS  = 32,
  parameter int IDX_W = 5
) (
  input  logic [ROWS-1:0]  onehot_i,
  output logic [IDX_W-1:0] index_o
);
  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    always_comb begin
      index_o[b] = 1'b0;
      for (int r = 0; r < ROWS; r++) begin
        if (((r >> b) & 1) == 1) index_o[b] = index_o[b] | onehot_i[r];
      end
    end
  end
endmodule

// File: rtl/mw_popcount.sv
module mw_popcount #(
  parameter int ROWS  = 32,
  parameter int CNT_W = 6
) (
  input  logic [ROWS-1:0]  vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int r = 0; r < ROWS; r++) begin
      cnt_o = cnt_o + CNT_W'(vec_i[r]);
    end
  end
endmodule

// File: rtl/match_walker.sv
module match_walker
  import mw_pkg::*;
#(
  parameter int ROWS  = 32,
  parameter int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  parameter int CNT_W = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             next_i,
  input  logic [ROWS-1:0]  match_i,
  output logic [ROWS-1:0]  sel_onehot_o,
  output logic [IDX_W-1:0] sel_index_o,
  output logic             sel_valid_o,
  output logic [CNT_W-1:0] match_count_o
);
  mw_cmd_e          cmd;
  logic [ROWS-1:0]  pend_q, pend_d;
  logic [ROWS-1:0]  pick_d;
  logic [IDX_W-1:0] idx_d;
  logic [CNT_W-1:0] pop_d;

  // load outranks advance
  always_comb begin
    if (load_i)      cmd = MW_LOAD;
    else if (next_i) cmd = MW_STEP;
    else             cmd = MW_HOLD;
  end

  always_comb begin
    unique case (cmd)
      MW_LOAD: pend_d = match_i;
      MW_STEP: pend_d = pend_q & ~sel_onehot_o;
      default: pend_d = pend_q;
    endcase
  end

  mw_first_pick #(.ROWS(ROWS)) u_pick (
    .pend_i (pend_d),
    .pick_o (pick_d)
  );

  mw_index_enc #(.ROWS(ROWS), .IDX_W(IDX_W)) u_enc (
    .onehot_i (pick_d),
    .index_o  (idx_d)
  );

  mw_popcount #(.ROWS(ROWS), .CNT_W(CNT_W)) u_pop (
    .vec_i (match_i),
    .cnt_o (pop_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= '0;
      sel_onehot_o  <= '0;
      sel_index_o   <= '0;
      sel_valid_o   <= 1'b0;
      match_count_o <= '0;
    end else begin
      if (cmd != MW_HOLD) begin
        pend_q       <= pend_d;
        sel_onehot_o <= pick_d;
        sel_index_o  <= idx_d;
        sel_valid_o  <= |pend_d;
      end
      if (cmd == MW_LOAD) match_count_o <= pop_d;
    end
  end
endmodule

// File: rtl/mw_checker.sv
module mw_checker #(
  parameter int ROWS  = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic             next_i,
  input logic [ROWS-1:0]  match_i,
  input logic [ROWS-1:0]  sel_onehot_o,
  input logic [IDX_W-1:0] sel_index_o,
  input logic             sel_valid_o,
  input logic [CNT_W-1:0] match_count_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!sel_valid_o && sel_onehot_o == '0 && match_count_o == '0));

  // R2
  single_select_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o |-> $countones(sel_onehot_o) == 1);

  // R3
  index_match_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o |-> sel_onehot_o[sel_index_o] == 1'b1);

  // R4
  load_count_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> int'(match_count_o) == $countones($past(match_i)));

  // R5
  retire_row_chk: assert property (@(posedge clk) disable iff (rst)
    (next_i && !load_i && sel_valid_o) |=>
      ((sel_onehot_o & $past(sel_onehot_o)) == '0 && (!sel_valid_o || sel_index_o > $past(sel_index_o))));

  // R6
  count_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(match_count_o));

  // R7
  empty_state_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_valid_o |-> (sel_onehot_o == '0 && sel_index_o == '0));

  // R8
  load_first_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && next_i && match_i[0]) |=> (sel_valid_o && sel_index_o == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !next_i) |=> ($stable(sel_onehot_o) && $stable(sel_index_o) && $stable(sel_valid_o)));
endmodule

bind match_walker mw_checker #(.ROWS(ROWS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_mw_chk (
  .clk           (clk),
  .rst           (rst),
  .load_i        (load_i),
  .next_i        (next_i),
  .match_i       (match_i),
  .sel_onehot_o  (sel_onehot_o),
  .sel_index_o   (sel_index_o),
  .sel_valid_o   (sel_valid_o),
  .match_count_o (match_count_o)
);

// File: tb/match_walker_bench.sv
module match_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 32;
  localparam int IDX_W = 5;
  localparam int CNT_W = 6;
  localparam int NVEC  = 6;
  localparam logic [ROWS-1:0] VECS [NVEC] = '{
    32'h0000_0001, 32'h8000_0000, 32'h0000_F00D,
    32'hA5A5_0000, 32'h8000_0001, 32'h1248_8421
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             load_i = 1'b0;
  logic             next_i = 1'b0;
  logic [ROWS-1:0]  match_i = '0;
  logic [ROWS-1:0]  sel_onehot_o;
  logic [IDX_W-1:0] sel_index_o;
  logic             sel_valid_o;
  logic [CNT_W-1:0] match_count_o;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_walker #(.ROWS(ROWS)) u_match_walker (
    .clk(clk), .rst(rst), .load_i(load_i), .next_i(next_i), .match_i(match_i),
    .sel_onehot_o(sel_onehot_o), .sel_index_o(sel_index_o),
    .sel_valid_o(sel_valid_o), .match_count_o(match_count_o)
  );

  function automatic int lowest(logic [ROWS-1:0] v);
    for (int r = 0; r < ROWS; r++) if (v[r]) return r;
    return -1;
  endfunction

  function automatic int ones(logic [ROWS-1:0] v);
    int c = 0;
    for (int r = 0; r < ROWS; r++) c += int'(v[r]);
    return c;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock with the given inputs; returns at the following negedge
  task automatic cycle(logic ld, logic nx, logic [ROWS-1:0] v);
    @(negedge clk);
    load_i = ld; next_i = nx; match_i = v;
    @(negedge clk);
    load_i = 1'b0; next_i = 1'b0;
  endtask

  // compare outputs against a model buffer
  task automatic expect_sel(string req, logic [ROWS-1:0] mbuf, int cnt);
    int lo = lowest(mbuf);
    if (lo < 0) begin
      check({req, " valid"}, sel_valid_o, 0);
      check({req, " onehot"}, sel_onehot_o, 0);
      check({req, " index"}, sel_index_o, 0);
    end else begin
      check({req, " valid"}, sel_valid_o, 1);
      check({req, " onehot"}, sel_onehot_o, longint'(ROWS'(1) << lo));
      check({req, " index"}, sel_index_o, lo);
    end
    check({req, " count"}, match_count_o, cnt);
  endtask

  initial begin
    logic [ROWS-1:0] mb;
    logic [ROWS-1:0] snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_sel("R1", '0, 0);
    rst = 1'b0;
    @(negedge clk);
    expect_sel("R1", '0, 0);

    // vector table walk: R2 R3 R4 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      mb = VECS[k];
      cycle(1'b1, 1'b0, mb);
      expect_sel("R2", mb, ones(VECS[k]));
      for (int s = 0; s < ROWS + 1 && mb != '0; s++) begin
        mb[lowest(mb)] = 1'b0;
        cycle(1'b0, 1'b1, '0);
        expect_sel("R5", mb, ones(VECS[k]));
      end
      // R7 advance on empty buffer is ignored
      cycle(1'b0, 1'b1, '0);
      expect_sel("R7", '0, ones(VECS[k]));
    end

    // R4 all rows set
    cycle(1'b1, 1'b0, '1);
    expect_sel("R4", '1, ROWS);

    // R8 load and advance in the same cycle while a walk is in progress
    cycle(1'b0, 1'b1, '0);
    mb = 32'h0000_000A;
    cycle(1'b1, 1'b1, mb);
    expect_sel("R8", mb, 2);
    mb[1] = 1'b0;
    cycle(1'b0, 1'b1, '0);
    expect_sel("R8", mb, 2);

    // R9 idle cycles hold everything, even with match_i changing
    snap = sel_onehot_o;
    cycle(1'b0, 1'b0, 32'hFFFF_0000);
    cycle(1'b0, 1'b0, 32'h0000_0F0F);
    check("R9 onehot", sel_onehot_o, snap);
    expect_sel("R9", mb, 2);

    // R3 top row index
    cycle(1'b1, 1'b0, 32'h8000_0000);
    check("R3 index", sel_index_o, ROWS - 1);

    // R7 loading an empty vector
    cycle(1'b1, 1'b0, '0);
    expect_sel("R7", '0, 0);

    // R1 reset mid-walk
    cycle(1'b1, 1'b0, 32'h0000_0F00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_sel("R1", '0, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule